// File: doc/BRIEF.md
# GPIO Pad Event Detector and Interrupt Aggregator

This block watches a bank of GPIO pads and turns activity on them into one shared interrupt line. Each pad input is first brought into the clock domain by a two-flop synchroniser. It can then be inverted, and is classified by a per-pad 2-bit event mode: level, single edge, both edges, or off. Each detected event sets a sticky status bit for that pad. A matching enable bit decides whether the pending bit reaches the interrupt. The interrupt output is a registered OR of every pad whose status and enable bits are both set.

Pads are packed into groups of `GRP_PADS` pads, and each group owns one 32-bit status word and one 32-bit enable word. Software reaches these words through a plain register port with these rules:
- A write is a single-cycle strobe.
- A read is a single-cycle strobe, and its data appears on the following clock edge.
- A 1 written to a status bit clears that bit.

The per-pad configuration (mode, invert, host ownership) arrives on plain input vectors, so the owner of the pad configuration registers drives them directly. The register port is a control interface, so it has no valid/ready handshake and never back-pressures.

Top module: `gpio_evt_irq_ctrl`

## Requirements
- R1: Mode 0 (level): while the qualified input is 1, the pad's status bit is set on every clock, so clearing it has no lasting effect while the level persists; the bit stays set after the level drops.
- R2: Mode 1 (edge): a 0-to-1 change of the qualified input sets the status bit once. A change of the pad input applied before clock edge k is reflected in the status bit at edge k+2, so a read strobed over edge k+3 is the first to return it.
- R3: Mode 3 (both edges): every change of the qualified input, rising or falling, sets the status bit.
- R4: Mode 2 (off): the pad never sets its status bit.
- R5: The invert bit complements the synchronised input before detection, so mode 1 with invert reacts to falling pad edges and mode 0 with invert to a low level; toggling the invert bit alone creates no edge.
- R6: Writing a word to a status address clears each bit written as 1 and leaves bits written as 0 unchanged; an event arriving in the same cycle as its clear wins, and the bit stays set.
- R7: `irq` goes to 1 one clock after some pad has both status and enable set, and returns to 0 one clock after no pad does.
- R8: The status word of group g is at byte address 0x100 + 4g and the enable word at 0x180 + 4g, with bit b holding pad g*GRP_PADS + b. Read data is registered on the edge where `reg_rd` is high; any other or misaligned address reads 0 and ignores writes.
- R9: Bits of a word that do not map to an existing pad (bit b ≥ GRP_PADS, or pad index ≥ NUM_PADS) always read 0 in both status and enable words.
- R10: A pad whose `pad_host_own` bit is 0 never sets its status bit.
- R11: Writing 0xFFFF to a group's status word and 0 to its enable word leaves that group fully cleared and masked, without touching other groups.
- R12: After reset all status bits, enable bits, `reg_rdata` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | NUM_PADS | Raw asynchronous pad inputs |
| pad_mode | input | 2*NUM_PADS | Event mode per pad, pad p in bits [2p+1:2p] |
| pad_inv | input | NUM_PADS | Input invert per pad |
| pad_host_own | input | NUM_PADS | 1 lets the pad update its status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Shared interrupt output |

## Verification
The bench sweeps every mode, with and without invert, across every pad of a 40-pad bank in three 16-pad groups, and computes the expected word bit from the pad index.

It aims at the following corner cases, and at what a wrong design would do in each:
- Level re-assertion after a clear: a design that treats level like an edge would lose the pending level.
- Falling edges in both-edge mode: a design that drops them would miss the event.
- The partial last group and upper word bits: a wrong design would read back phantom bits.
- A clear landing in the same cycle as a new edge: an edge would be lost silently.
- Unowned pads: a wrong design would raise status on them.
- The one-cycle delays of status, read data and `irq`: an extra or missing register stage shows up as an off-by-one sample.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    EVT_LEVEL = 2'd0,
    EVT_EDGE  = 2'd1,
    EVT_OFF   = 2'd2,
    EVT_BOTH  = 2'd3
  } evt_mode_e;

  localparam int REG_DATA_W = 32;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PADS-1:0]   sync_in,
  input  logic [2*NUM_PADS-1:0] mode,
  input  logic [NUM_PADS-1:0]   inv,
  output logic [NUM_PADS-1:0]   evt
);
  logic [NUM_PADS-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= sync_in;
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    evt_mode_e m;
    logic      cur_q, old_q;
    assign m     = evt_mode_e'(mode[2*p +: 2]);
    // invert applied to both samples: flipping inv alone is no edge
    assign cur_q = sync_in[p] ^ inv[p];
    assign old_q = prev[p] ^ inv[p];

    always_comb begin
      unique case (m)
        EVT_LEVEL: evt[p] = cur_q;
        EVT_EDGE:  evt[p] = cur_q & ~old_q;
        EVT_BOTH:  evt[p] = cur_q ^ old_q;
        default:   evt[p] = 1'b0;
      endcase
    end

    p_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (m == EVT_OFF) |-> !evt[p]);

    p_edge_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((m == EVT_EDGE || m == EVT_BOTH) && evt[p]) |-> (sync_in[p] != $past(sync_in[p])));
  end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 40,
  parameter int GRP_PADS = 16,
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h100,
  parameter logic [ADDR_W-1:0] EN_BASE   = 'h180
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PADS-1:0]   evt,
  input  logic [NUM_PADS-1:0]   own,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  output logic                  irq
);
  localparam int GRPS   = (NUM_PADS + GRP_PADS - 1) / GRP_PADS;
  localparam int TOTAL  = GRPS * GRP_PADS;
  localparam int GIDX_W = (GRPS > 1) ? $clog2(GRPS) : 1;
  localparam int SPAN   = 4 * GRPS;

  logic [NUM_PADS-1:0] status, enable;
  logic [NUM_PADS-1:0] clr_mask, en_wr, wbit, set_mask;
  logic [ADDR_W-1:0]   stat_off, en_off;
  logic                stat_hit, en_hit;
  logic [GIDX_W-1:0]   acc_grp;
  logic [TOTAL-1:0]    stat_pad, en_pad;
  logic [GRP_PADS-1:0] sel_word;
  logic [REG_DATA_W-1:0] rd_next;

  // address decode
  assign stat_off = reg_addr - STAT_BASE;
  assign en_off   = reg_addr - EN_BASE;
  assign stat_hit = (reg_addr >= STAT_BASE) && (stat_off < ADDR_W'(SPAN)) && (reg_addr[1:0] == 2'b00);
  assign en_hit   = (reg_addr >= EN_BASE) && (en_off < ADDR_W'(SPAN)) && (reg_addr[1:0] == 2'b00);
  assign acc_grp  = stat_hit ? stat_off[GIDX_W+1:2] : en_off[GIDX_W+1:2];

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_bit
    localparam int G = p / GRP_PADS;
    localparam int B = p % GRP_PADS;
    logic grp_sel;
    assign grp_sel     = (acc_grp == GIDX_W'(G));
    assign wbit[p]     = reg_wdata[B];
    assign clr_mask[p] = reg_wr & stat_hit & grp_sel & reg_wdata[B];
    assign en_wr[p]    = reg_wr & en_hit & grp_sel;
  end

  assign set_mask = evt & own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      // set wins over a same-cycle clear
      status <= (status & ~clr_mask) | set_mask;
      enable <= (enable & ~en_wr) | (wbit & en_wr);
    end
  end

  // readback: pad vectors widened to whole groups, missing pads read 0
  assign stat_pad = TOTAL'(status);
  assign en_pad   = TOTAL'(enable);
  assign sel_word = stat_hit ? stat_pad[int'(acc_grp) * GRP_PADS +: GRP_PADS]
                             : en_pad[int'(acc_grp) * GRP_PADS +: GRP_PADS];
  assign rd_next  = (stat_hit || en_hit) ? REG_DATA_W'(sel_word) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_next;
      irq <= |(status & enable);
    end
  end

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && stat_hit) |=> ((status & $past(clr_mask & ~set_mask)) == '0));

  p_unowned_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(own)) == '0));

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|enable));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !stat_hit && !en_hit) |=> (reg_rdata == '0));
endmodule

// File: rtl/gpio_evt_irq_ctrl.sv
module gpio_evt_irq_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PADS = 40,
  parameter int GRP_PADS = 16,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PADS-1:0]   pad_in,
  input  logic [2*NUM_PADS-1:0] pad_mode,
  input  logic [NUM_PADS-1:0]   pad_inv,
  input  logic [NUM_PADS-1:0]   pad_host_own,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  output logic                  irq
);
  logic [NUM_PADS-1:0] pad_sync, pad_evt;

  gpio_evt_sync #(.W(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpio_evt_detect #(.NUM_PADS(NUM_PADS)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_in(pad_sync),
    .mode(pad_mode), .inv(pad_inv), .evt(pad_evt)
  );

  gpio_evt_bank #(
    .NUM_PADS(NUM_PADS), .GRP_PADS(GRP_PADS), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(pad_evt), .own(pad_host_own),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: tb/tb_gpio_evt_irq_ctrl.sv
module tb_gpio_evt_irq_ctrl;
  localparam int NP = 40;
  localparam int GP = 16;
  localparam int NG = (NP + GP - 1) / GP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad_in = '0;
  logic [2*NP-1:0] pad_mode;
  logic [NP-1:0] pad_inv = '0;
  logic [NP-1:0] pad_own = '1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;
  int checks = 0, errors = 0;
  logic [31:0]   rv;

  always #4 clk = ~clk;

  gpio_evt_irq_ctrl #(.NUM_PADS(NP), .GRP_PADS(GP), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_mode(pad_mode),
    .pad_inv(pad_inv), .pad_host_own(pad_own), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [11:0] st_a(int g); return 12'(12'h100 + 4 * g); endfunction
  function automatic logic [11:0] en_a(int g); return 12'(12'h180 + 4 * g); endfunction
  function automatic logic [31:0] pbit(int p); return 32'(1) << (p % GP); endfunction

  function automatic string mtag(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic clear_all();
    for (int g = 0; g < NG; g++) wr_reg(st_a(g), 32'hFFFF_FFFF);
  endtask

  task automatic all_off();
    for (int p = 0; p < NP; p++) pad_mode[2*p +: 2] = 2'd2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    all_off();
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    check("R12 rdata", reg_rdata, 32'h0);
    check("R12 irq", {31'b0, irq}, 32'h0);
    for (int g = 0; g < NG; g++) begin
      rd_reg(st_a(g), rv); check("R12 status", rv, 32'h0);
      rd_reg(en_a(g), rv); check("R12 enable", rv, 32'h0);
    end

    // sweep: every mode, both polarities, every pad
    for (int m = 0; m < 4; m++)
      for (int iv = 0; iv < 2; iv++)
        for (int p = 0; p < NP; p++) begin
          string t;
          int g;
          g = p / GP;
          t = $sformatf("%s%s pad%0d", mtag(m), (iv != 0) ? "/R5" : "", p);
          all_off();
          pad_mode[2*p +: 2] = 2'(m);
          pad_inv = {NP{iv[0]}};
          pad_in  = {NP{iv[0]}};
          tick(4);
          clear_all();
          pad_in[p] = ~iv[0];
          tick(4);
          rd_reg(st_a(g), rv);
          check({t, " rise"}, rv, (m != 2) ? pbit(p) : 32'h0);
          wr_reg(st_a(g), pbit(p));
          tick(3);
          rd_reg(st_a(g), rv);
          check({t, " after clear"}, rv, (m == 0) ? pbit(p) : 32'h0);
          pad_in[p] = iv[0];
          tick(4);
          rd_reg(st_a(g), rv);
          check({t, " fall"}, rv, (m == 0 || m == 3) ? pbit(p) : 32'h0);
          check("R7 no enable no irq", {31'b0, irq}, 32'h0);
        end
    all_off(); pad_inv = '0; pad_in = '0; tick(4); clear_all();

    // R5: flipping invert alone is no edge
    pad_mode[2*6 +: 2] = 2'd3; tick(3); clear_all();
    pad_inv[6] = 1'b1; tick(4);
    rd_reg(st_a(0), rv); check("R5 invert toggle", rv, 32'h0);
    pad_inv[6] = 1'b0; all_off(); tick(2);

    // R2 latency: status visible to a read strobed over edge k+3
    pad_mode[2*7 +: 2] = 2'd1; tick(3); clear_all();
    pad_in[7] = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_reg(st_a(0), rv); check("R2 latency k+1", rv, 32'h0);
    rd_reg(st_a(0), rv); check("R2 latency k+2", rv, 32'h0);
    rd_reg(st_a(0), rv); check("R2 latency k+3", rv, pbit(7));

    // R6: writing 0 leaves bits, same-cycle clear loses to event
    wr_reg(st_a(0), 32'h0);
    rd_reg(st_a(0), rv); check("R6 write zero keeps", rv, pbit(7));
    pad_in[7] = 1'b0; tick(4); clear_all();
    pad_mode[2*3 +: 2] = 2'd1; tick(2); clear_all();
    pad_in[3] = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    reg_wr = 1'b1; reg_addr = st_a(0); reg_wdata = pbit(3);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    rd_reg(st_a(0), rv); check("R6 event beats clear", rv, pbit(3));
    wr_reg(st_a(0), pbit(3));
    rd_reg(st_a(0), rv); check("R6 clear", rv, 32'h0);
    pad_in = '0; all_off(); tick(4); clear_all();

    // R7 irq timing
    pad_mode[2*5 +: 2] = 2'd0; pad_in[5] = 1'b1; tick(4);
    check("R7 masked", {31'b0, irq}, 32'h0);
    wr_reg(en_a(0), pbit(5));
    check("R7 irq one cycle later", {31'b0, irq}, 32'h0);
    tick(1);
    check("R7 irq up", {31'b0, irq}, 32'h1);
    wr_reg(en_a(0), 32'h0);
    check("R7 irq holds one cycle", {31'b0, irq}, 32'h1);
    tick(1);
    check("R7 irq down", {31'b0, irq}, 32'h0);
    pad_in = '0; all_off(); tick(4); clear_all();

    // R11 group clear and mask
    for (int p = 0; p < 4; p++) pad_mode[2*p +: 2] = 2'd1;
    pad_mode[2*20 +: 2] = 2'd1;
    tick(2);
    pad_in[3:0] = 4'hF; pad_in[20] = 1'b1;
    tick(4);
    wr_reg(en_a(0), 32'h0000_000F);
    tick(2);
    check("R11 irq before", {31'b0, irq}, 32'h1);
    wr_reg(st_a(0), 32'h0000_FFFF);
    wr_reg(en_a(0), 32'h0);
    tick(2);
    rd_reg(st_a(0), rv); check("R11 status cleared", rv, 32'h0);
    rd_reg(en_a(0), rv); check("R11 enable cleared", rv, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    rd_reg(st_a(1), rv); check("R11 other group kept", rv, pbit(20));
    pad_in = '0; all_off(); tick(4); clear_all();

    // R10 ownership
    pad_mode[2*9 +: 2] = 2'd0; pad_own[9] = 1'b0; pad_in[9] = 1'b1;
    tick(6);
    rd_reg(st_a(0), rv); check("R10 unowned", rv, 32'h0);
    pad_own[9] = 1'b1; tick(3);
    rd_reg(st_a(0), rv); check("R10 owned again", rv, pbit(9));
    pad_in = '0; all_off(); tick(4); clear_all();

    // R9 nonexistent bits
    wr_reg(en_a(2), 32'hFFFF_FFFF);
    rd_reg(en_a(2), rv); check("R9 last group enable", rv, 32'h0000_00FF);
    wr_reg(en_a(0), 32'hFFFF_FFFF);
    rd_reg(en_a(0), rv); check("R9 upper bits", rv, 32'h0000_FFFF);
    pad_mode[2*39 +: 2] = 2'd0; pad_in[39] = 1'b1; tick(4);
    rd_reg(st_a(2), rv); check("R9 last pad", rv, 32'h0000_0080);
    pad_in = '0; all_off(); tick(4); clear_all();
    wr_reg(en_a(0), 32'h0); wr_reg(en_a(2), 32'h0);

    // R8 address map
    wr_reg(en_a(1), 32'h0000_1234);
    rd_reg(en_a(1), rv); check("R8 enable group1", rv, 32'h0000_1234);
    rd_reg(12'h10C, rv); check("R8 unmapped status", rv, 32'h0);
    rd_reg(12'h18C, rv); check("R8 unmapped enable", rv, 32'h0);
    rd_reg(12'h185, rv); check("R8 misaligned", rv, 32'h0);
    wr_reg(12'h185, 32'hFFFF_FFFF);
    rd_reg(en_a(1), rv); check("R8 misaligned write ignored", rv, 32'h0000_1234);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule